// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the combinational execute stage for a 32-bit data-processing instruction. It receives an already decoded 4-bit operation code, a set-flags bit, the first operand, a second operand that an upstream shifter has already produced, and that shifter's carry-out. It also receives the current N, Z, C and V flags. From these it forms the 32-bit result, a register write strobe, a program-counter write strobe, the next flag values and an indication that the encoding is unpredictable.

A single shared adder serves all eight arithmetic operations. Per operation it selects the operand order, whether the subtrahend is inverted, and which carry-in to use. The logical operations use a small bitwise unit instead. Control logic decides where the result goes and whether the flags change. That decision depends on the destination index, the condition-passed input, the set-flags bit and whether the register-shifted-register form is in use. Instruction decode, immediate expansion, the barrel shifter, condition evaluation and the register file all sit outside this block.

Top module: `dp_exec_unit`

## Requirements
- R1: The opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The logical results are: AND/TST give a&b, EOR/TEQ give a^b, ORR gives a|b, MOV gives b, BIC gives a&~b, and MVN gives ~b.
- R2: ADD and CMN produce a+b with a carry-in of 0. ADC produces a+b plus the incoming C flag.
- R3: SUB and CMP produce a+~b with a carry-in of 1. SBC produces a+~b plus the incoming C flag.
- R4: RSB produces b+~a with a carry-in of 1. RSC produces b+~a plus the incoming C flag.
- R5: When an arithmetic operation updates the flags, N is result bit 31 and Z is set for a zero result. C is the adder carry out of bit 31. V is set when the two adder inputs, after any inversion, share a sign and the sum's sign differs from it. Flag bits are packed as {N,Z,C,V} with N as bit 3.
- R6: When a logical operation updates the flags, N and Z come from the result and C is the shifter carry-out. V keeps its incoming value.
- R7: TST, TEQ, CMP and CMN never raise the register or PC write strobe, and they update the flags even when the set-flags bit is 0.
- R8: A non-test operation with the set-flags bit at 0 leaves the flags equal to their incoming values.
- R9: A non-test operation whose destination index is 15 raises the PC write strobe instead of the register write strobe. Any other destination raises the register write strobe.
- R10: If a non-test operation targets index 15 with the set-flags bit at 1 while the condition passes, the unpredictable flag is raised. No write strobe is raised and the flags hold.
- R11: In the register-shifted-register form, the unpredictable flag is raised, whatever the condition, when any checked index equals 15. The shift and second-operand indices are always checked. The destination is checked except for test operations, and the first-operand index is checked except for MOV and MVN. While the flag is up, no write strobe is raised and the flags hold.
- R12: When the condition-passed input is 0, both write strobes stay low and the flags equal their incoming values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (R1 encoding) |
| set_flags | input | 1 | Request to update flags |
| cond_ok | input | 1 | Condition evaluated as passed |
| rsr_form | input | 1 | Shift amount came from a register |
| rd_idx | input | 4 | Destination register index |
| rn_idx | input | 4 | First-operand register index |
| rs_idx | input | 4 | Shift-amount register index |
| rm_idx | input | 4 | Second-operand register index |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_cy | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current {N,Z,C,V} |
| result | output | 32 | Operation result |
| reg_we | output | 1 | Register write strobe |
| pc_we | output | 1 | Program-counter write strobe |
| flags_out | output | 4 | Next {N,Z,C,V} |
| unpred | output | 1 | Unpredictable encoding detected |

## Verification
The assertions assume that every input is driven to a known 0/1 value, since the block holds no state and each check compares outputs directly with inputs in the same cycle. They also assume the upstream stages follow the stated index convention, in which index 15 names the program counter. The stimulus meets both assumptions by driving each input from explicit loops over opcodes, carry values, flag patterns and index choices. Only fully defined values are used, and each vector is allowed to settle before the outputs are sampled.

// File: rtl/dp_exec_pkg.sv
// Package: shared opcode encoding, flag bit positions and operation class helpers.
// Assumes the 4-bit opcode field arrives exactly as decoded upstream.
package dp_exec_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // True for the compare/test group, which never writes a register.
    function automatic logic op_is_test(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    // True for operations that go through the adder.
    function automatic logic op_is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction

endpackage

// File: rtl/dp_adder.sv
// Module: shared adder for all arithmetic operations.
// Chooses operand order, inversion and carry-in per opcode; outputs sum,
// carry-out of the top bit and signed overflow. Assumes op is arithmetic
// when its outputs are used; other opcodes fall back to a plain a+b.
module dp_adder
    import dp_exec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             c_flag,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_ci;
    logic [WIDTH:0]   wide_sum;

    // Select adder inputs and carry-in for the current opcode.
    always_comb begin
        add_x  = opnd_a;
        add_y  = opnd_b;
        add_ci = 1'b0;
        case (op)
            OP_ADD, OP_CMN: begin add_x = opnd_a; add_y = opnd_b;  add_ci = 1'b0;   end
            OP_ADC:         begin add_x = opnd_a; add_y = opnd_b;  add_ci = c_flag; end
            OP_SUB, OP_CMP: begin add_x = opnd_a; add_y = ~opnd_b; add_ci = 1'b1;   end
            OP_SBC:         begin add_x = opnd_a; add_y = ~opnd_b; add_ci = c_flag; end
            OP_RSB:         begin add_x = opnd_b; add_y = ~opnd_a; add_ci = 1'b1;   end
            OP_RSC:         begin add_x = opnd_b; add_y = ~opnd_a; add_ci = c_flag; end
            default:        begin add_x = opnd_a; add_y = opnd_b;  add_ci = 1'b0;   end
        endcase
    end

    // One carry-propagate add with an extra bit to capture carry-out.
    always_comb begin
        wide_sum  = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};
        sum       = wide_sum[MSB:0];
        carry_out = wide_sum[WIDTH];
        overflow  = (add_x[MSB] == add_y[MSB]) && (wide_sum[MSB] != add_x[MSB]);
    end

endmodule

// File: rtl/dp_logic.sv
// Module: bitwise unit for the logical, move and test operations.
// Assumes opnd_b has already passed through the shifter.
module dp_logic
    import dp_exec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] lres
);
    // Pick the bitwise function for the opcode.
    always_comb begin
        case (op)
            OP_AND, OP_TST: lres = opnd_a & opnd_b;
            OP_EOR, OP_TEQ: lres = opnd_a ^ opnd_b;
            OP_ORR:         lres = opnd_a | opnd_b;
            OP_MOV:         lres = opnd_b;
            OP_BIC:         lres = opnd_a & ~opnd_b;
            OP_MVN:         lres = ~opnd_b;
            default:        lres = opnd_a & opnd_b;
        endcase
    end

endmodule

// File: rtl/dp_ctrl.sv
// Module: write-back routing, unpredictable detection and flag selection.
// Assumes index PC_IDX names the program counter and that the condition
// was evaluated upstream.
module dp_ctrl
    import dp_exec_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int IDX_W   = 4,
    parameter int PC_IDX  = 15
) (
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic             cond_ok,
    input  logic             rsr_form,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rn_idx,
    input  logic [IDX_W-1:0] rs_idx,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic [WIDTH-1:0] sum,
    input  logic             carry_out,
    input  logic             overflow,
    input  logic [WIDTH-1:0] lres,
    input  logic             shift_cy,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic             reg_we,
    output logic             pc_we,
    output logic [3:0]       flags_out,
    output logic             unpred
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    logic is_test, is_arith, writes, to_pc, uses_rn, rsr_bad, active, upd;
    logic [3:0] next_flags;

    // Classify the operation and its destination.
    always_comb begin
        is_test  = op_is_test(op);
        is_arith = op_is_arith(op);
        writes   = !is_test;
        to_pc    = rd_idx == PC_SEL;
        uses_rn  = (op != OP_MOV) && (op != OP_MVN);
    end

    // Detect unpredictable encodings; the register-shift case ignores the condition.
    always_comb begin
        rsr_bad = rsr_form && ((rm_idx == PC_SEL) || (rs_idx == PC_SEL) ||
                               (writes && to_pc) || (uses_rn && rn_idx == PC_SEL));
        unpred  = rsr_bad || (cond_ok && writes && to_pc && set_flags);
        active  = cond_ok && !unpred;
    end

    // Route the result and raise the matching write strobe.
    always_comb begin
        result = is_arith ? sum : lres;
        reg_we = active && writes && !to_pc;
        pc_we  = active && writes && to_pc;
    end

    // Form candidate flags and choose between them and the held flags.
    always_comb begin
        next_flags[FLAG_N] = result[WIDTH-1];
        next_flags[FLAG_Z] = result == '0;
        next_flags[FLAG_C] = is_arith ? carry_out : shift_cy;
        next_flags[FLAG_V] = is_arith ? overflow  : flags_in[FLAG_V];
        upd                = active && (set_flags || is_test);
        flags_out          = upd ? next_flags : flags_in;
    end

endmodule

// File: rtl/dp_exec_unit.sv
// Module: top of the data-processing execute stage (purely combinational).
// Joins the shared adder, the bitwise unit and the write-back control.
// Assumes operands and flags are stable for the whole evaluation.
module dp_exec_unit
    import dp_exec_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic             cond_ok,
    input  logic             rsr_form,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rn_idx,
    input  logic [IDX_W-1:0] rs_idx,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             shift_cy,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic             reg_we,
    output logic             pc_we,
    output logic [3:0]       flags_out,
    output logic             unpred
);
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] lres;
    logic             carry_out;
    logic             overflow;

    dp_adder #(.WIDTH(WIDTH)) u_add (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .c_flag(flags_in[FLAG_C]),
        .sum(sum), .carry_out(carry_out), .overflow(overflow)
    );

    dp_logic #(.WIDTH(WIDTH)) u_log (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .lres(lres)
    );

    dp_ctrl #(.WIDTH(WIDTH), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_ctl (
        .op(op), .set_flags(set_flags), .cond_ok(cond_ok), .rsr_form(rsr_form),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rs_idx(rs_idx), .rm_idx(rm_idx),
        .sum(sum), .carry_out(carry_out), .overflow(overflow), .lres(lres),
        .shift_cy(shift_cy), .flags_in(flags_in), .result(result),
        .reg_we(reg_we), .pc_we(pc_we), .flags_out(flags_out), .unpred(unpred)
    );

endmodule

// File: rtl/dp_exec_checker.sv
// Checker: port-level rules of the execute unit, bound to every instance.
// The unit holds no state, so each rule is an immediate check on settled values.
module dp_exec_checker #(
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input logic [3:0]       op,
    input logic             set_flags,
    input logic             cond_ok,
    input logic [IDX_W-1:0] rd_idx,
    input logic [3:0]       flags_in,
    input logic             reg_we,
    input logic             pc_we,
    input logic [3:0]       flags_out,
    input logic             unpred
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    // Check the routing and hold rules whenever any input or output changes.
    always_comb begin
        a_r7_test_no_write: assert (!(op[3:2] == 2'b10) || (!reg_we && !pc_we))
            else $error("test op raised a write strobe");
        a_r9_one_strobe: assert (!(reg_we && pc_we))
            else $error("both write strobes high");
        a_r9_pc_route: assert (!(rd_idx == PC_SEL) || !reg_we)
            else $error("register strobe for index 15");
        a_r12_cond_fail_quiet: assert (cond_ok || (!reg_we && !pc_we && flags_out == flags_in))
            else $error("activity with condition failed");
        a_r10_unpred_quiet: assert (!unpred || (!reg_we && !pc_we && flags_out == flags_in))
            else $error("activity while unpredictable");
        a_r8_no_s_hold: assert (set_flags || (op[3:2] == 2'b10) || flags_out == flags_in)
            else $error("flags moved without set-flags");
    end

endmodule

bind dp_exec_unit dp_exec_checker #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_chk (
    .op(op), .set_flags(set_flags), .cond_ok(cond_ok), .rd_idx(rd_idx),
    .flags_in(flags_in), .reg_we(reg_we), .pc_we(pc_we),
    .flags_out(flags_out), .unpred(unpred)
);

// File: tb/sim_dp_exec_unit.sv
module sim_dp_exec_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [3:0]  op;
    logic        set_flags, cond_ok, rsr_form, shift_cy;
    logic [3:0]  rd_idx, rn_idx, rs_idx, rm_idx, flags_in;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic        reg_we, pc_we, unpred;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    dp_exec_unit u0 (
        .op(op), .set_flags(set_flags), .cond_ok(cond_ok), .rsr_form(rsr_form),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rs_idx(rs_idx), .rm_idx(rm_idx),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_cy(shift_cy), .flags_in(flags_in),
        .result(result), .reg_we(reg_we), .pc_we(pc_we),
        .flags_out(flags_out), .unpred(unpred)
    );

    logic [31:0] e_res;
    logic        e_we, e_pcw, e_un;
    logic [3:0]  e_fl;

    // Reference behaviour derived from the requirements.
    task automatic model();
        logic test, arith, writes, pc, bad, act, upd;
        logic [32:0] s;
        logic [31:0] x, y;
        logic ci;
        test   = op >= 8 && op <= 11;
        arith  = (op >= 2 && op <= 7) || op == 10 || op == 11;
        writes = !test;
        pc     = rd_idx == 15;
        bad    = rsr_form && (rm_idx == 15 || rs_idx == 15 || (writes && pc) ||
                              (op != 13 && op != 15 && rn_idx == 15));
        e_un   = bad || (cond_ok && writes && pc && set_flags);
        act    = cond_ok && !e_un;
        x = opnd_a; y = opnd_b; ci = 1'b0;
        case (op)
            5:      ci = flags_in[1];
            2, 10:  begin y = ~opnd_b; ci = 1'b1; end
            6:      begin y = ~opnd_b; ci = flags_in[1]; end
            3:      begin x = opnd_b; y = ~opnd_a; ci = 1'b1; end
            7:      begin x = opnd_b; y = ~opnd_a; ci = flags_in[1]; end
            default: ;
        endcase
        s = 33'(x) + 33'(y) + 33'(ci);
        case (op)
            0, 8:  e_res = opnd_a & opnd_b;
            1, 9:  e_res = opnd_a ^ opnd_b;
            12:    e_res = opnd_a | opnd_b;
            13:    e_res = opnd_b;
            14:    e_res = opnd_a & ~opnd_b;
            15:    e_res = ~opnd_b;
            default: e_res = s[31:0];
        endcase
        e_we  = act && writes && !pc;
        e_pcw = act && writes && pc;
        upd   = act && (set_flags || test);
        if (!upd) e_fl = flags_in;
        else if (arith)
            e_fl = {e_res[31], e_res == 0, s[32], (x[31] == y[31]) && (s[31] != x[31])};
        else
            e_fl = {e_res[31], e_res == 0, shift_cy, flags_in[0]};
    endtask

    task automatic chk1(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d actual=%h expected=%h", tag, what, op, act, exp);
        end
    endtask

    // Apply one vector, let it settle, compare every output.
    task automatic apply(logic [3:0] o, logic s, logic c, logic rsr, logic [3:0] rd,
                         logic [3:0] rn, logic [3:0] rs, logic [3:0] rm,
                         logic [31:0] a, logic [31:0] b, logic scy, logic [3:0] fi);
        string rt, ft, wt, ut;
        @(posedge clk); #1;
        op = o; set_flags = s; cond_ok = c; rsr_form = rsr; rd_idx = rd; rn_idx = rn;
        rs_idx = rs; rm_idx = rm; opnd_a = a; opnd_b = b; shift_cy = scy; flags_in = fi;
        @(negedge clk);
        model();
        rt = (o == 4 || o == 5 || o == 11) ? "R2" : (o == 2 || o == 6 || o == 10) ? "R3" :
             (o == 3 || o == 7) ? "R4" : "R1";
        if (!c) ft = "R12";
        else if (e_un) ft = rsr ? "R11" : "R10";
        else if (o >= 8 && o <= 11) ft = "R7";
        else if (!s) ft = "R8";
        else ft = ((o >= 2 && o <= 7)) ? "R5" : "R6";
        wt = !c ? "R12" : e_un ? (rsr ? "R11" : "R10") : (o >= 8 && o <= 11) ? "R7" : "R9";
        ut = rsr ? "R11" : "R10";
        chk1(rt, result, e_res, "result");
        chk1(ft, 32'(flags_out), 32'(e_fl), "flags");
        chk1(wt, 32'(reg_we), 32'(e_we), "reg_we");
        chk1(wt, 32'(pc_we), 32'(e_pcw), "pc_we");
        chk1(ut, 32'(unpred), 32'(e_un), "unpred");
    endtask

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return 32'h1234_5678;
        endcase
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 0; set_flags = 0; cond_ok = 0; rsr_form = 0; rd_idx = 0; rn_idx = 0;
        rs_idx = 0; rm_idx = 0; opnd_a = 0; opnd_b = 0; shift_cy = 0; flags_in = 0;
        // Idle state: all-zero inputs, condition failed, nothing written (R12).
        apply(4'd0, 0, 0, 0, 4'd0, 4'd0, 4'd0, 4'd0, 0, 0, 0, 4'h0);
        // Main sweep R1..R9, R12: every opcode, S, carry, condition, destination.
        for (int o = 0; o < 16; o++)
            for (int s = 0; s < 2; s++)
                for (int cf = 0; cf < 2; cf++)
                    for (int c = 0; c < 2; c++)
                        for (int d = 0; d < 2; d++)
                            for (int ia = 0; ia < 6; ia++)
                                for (int ib = 0; ib < 6; ib++)
                                    apply(4'(o), 1'(s), 1'(c), 0, d ? 4'd15 : 4'd3,
                                          4'd1, 4'd2, 4'd4, pat(ia), pat(ib),
                                          1'((ia + ib) & 1), {2'(ia), 1'(cf), 1'(ib & 1)});
        // Register-shift form R11: each index in turn set to 15, both conditions.
        for (int o = 0; o < 16; o++)
            for (int c = 0; c < 2; c++)
                for (int w = 0; w < 5; w++)
                    apply(4'(o), 1'(w & 1), 1'(c), 1,
                          w == 1 ? 4'd15 : 4'd5, w == 2 ? 4'd15 : 4'd6,
                          w == 3 ? 4'd15 : 4'd7, w == 4 ? 4'd15 : 4'd8,
                          32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 4'b0101);
        // Directed corners: R10 MOV to index 15 with S, R11 MVN ignores first-operand index.
        apply(4'd13, 1, 1, 0, 4'd15, 4'd0, 4'd0, 4'd0, 0, 32'h10, 0, 4'h3);
        apply(4'd15, 1, 1, 1, 4'd2, 4'd15, 4'd3, 4'd4, 0, 32'h10, 1, 4'h0);
        // R5 overflow corner: 0x7FFFFFFF + 1 with ADDS.
        apply(4'd4, 1, 1, 0, 4'd1, 4'd0, 4'd0, 4'd0, 32'h7FFF_FFFF, 1, 0, 4'h0);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule